// File: doc/BRIEF.md
# SDRAM Command Gate with Stall Timer and Clock-Enable Power-Down

This block sits between an SDRAM request scheduler and the memory command pins. Each memory clock it decides whether the pending request may go out. It holds the command pins at NOP during timed stall windows, and it drops the clock enable (CKE) while the chip select has no work. It also writes the auto-precharge flag of read and write commands into an address bit chosen by configuration.

One timer produces every stall. A stall lasts (N+1)*16 memory clocks, where N comes from the configuration word. Two events start it. The first is a pulse that marks exit from self refresh. The second is software setting a blackout bit, which stops all transactions for the same length of time. The memory clock is either the bus clock itself or a qualified half-rate clock, selected by a ratio bit. When the half rate is selected, the `mclk_en` input marks which bus cycles are memory clocks.

Top module: `sdram_cmd_gate`

## Requirements
- R1: After reset, `cmd_out` is NOP (code 0), `cke` is 1, `addr_out` is 0 and no stall is running. With the all-zero configuration word, `req_ready` equals `mclk_en`.
- R2: A pulse on `sr_exit` starts a stall. During the stall, `req_ready` stays low for exactly (N+1)*16 memory clocks, where N is configuration bits 4:0. `req_ready` returns high in the next memory clock.
- R3: A 0-to-1 change of configuration bit 7 starts a stall of the same length. Keeping bit 7 high starts nothing more. Clearing bit 7 and then setting it again starts a new stall.
- R4: During a stall, `cmd_out` stays NOP and no request is granted, even when `req_valid` is high. A request held across the stall is granted when `req_ready` returns.
- R5: When configuration bit 26 is 1, `cs_idle` is 1 and no request is pending, `cke` goes low at the next memory clock. When bit 26 is 0, `cke` stays high.
- R6: A pending request, refresh included, raises `cke` while it is low. `req_ready` stays low until `cke` has been high for one memory clock. The command therefore appears on `cmd_out` at least one memory clock after `cke` rises.
- R7: For READ (code 2) and WRITE (code 3), the auto-precharge flag `req_ap` replaces one bit of the output address. Configuration bits 25:24 = 00 select bit 10, 01 selects bit 8, and 10 or 11 select bit 10. Other commands pass their address through unchanged.
- R8: Configuration bit 15 = 1 makes every bus clock a memory clock. Bit 15 = 0 makes only bus clocks with `mclk_en` high count as memory clocks. Stalls are counted in memory clocks.
- R9: The reserved configuration bits 31:29, 27, 23:20, 18, 16, 14:8 and 6:5 have no effect.
- R10: A granted request appears on `cmd_out` and `addr_out` in the memory clock after the grant. When nothing is granted in a memory clock, `cmd_out` returns to NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Configuration word (stall count, blackout, ratio, precharge pin select, power mode) |
| mclk_en | input | 1 | Marks memory-clock cycles when running at half rate |
| req_valid | input | 1 | Scheduler has a command pending |
| req_ready | output | 1 | Command accepted this cycle when high with req_valid |
| req_cmd | input | 3 | Command code: 0 NOP, 1 ACT, 2 READ, 3 WRITE, 4 PRE, 5 REFRESH, 6 MODE |
| req_addr | input | ADDR_W | Command address |
| req_ap | input | 1 | Auto-precharge flag for READ/WRITE |
| sr_exit | input | 1 | One-cycle pulse on exit from self refresh |
| cs_idle | input | 1 | Chip select currently has no open work |
| cmd_out | output | 3 | Command driven to the memory pins |
| cke | output | 1 | Memory clock enable |
| addr_out | output | ADDR_W | Formatted address driven to the pins |

## Verification
The assertions assume that the configuration word changes only between memory clocks. They also assume that `sr_exit` is a single-cycle pulse, and that `req_cmd`, `req_addr` and `req_ap` hold steady while `req_valid` waits for `req_ready`. The bench drives every input on the falling edge, so each change lands whole between rising edges. It raises `sr_exit` for exactly one cycle. It keeps a request unchanged until it has seen the grant at the port.

// File: rtl/sdcg_pkg.sv
package sdcg_pkg;
   localparam logic [2:0] CMD_NOP = 3'd0;
   localparam logic [2:0] CMD_ACT = 3'd1;
   localparam logic [2:0] CMD_RD  = 3'd2;
   localparam logic [2:0] CMD_WR  = 3'd3;
   localparam logic [2:0] CMD_PRE = 3'd4;
   localparam logic [2:0] CMD_REF = 3'd5;
   localparam logic [2:0] CMD_MRS = 3'd6;

   localparam int CFG_BLK_BIT   = 7;
   localparam int CFG_RATIO_BIT = 15;
   localparam int CFG_APSEL_LSB = 24;
   localparam int CFG_PM_BIT    = 26;

   function automatic logic is_rw(input logic [2:0] c);
      return (c == CMD_RD) || (c == CMD_WR);
   endfunction
endpackage

// File: rtl/sdcg_stall.sv
module sdcg_stall #(
   parameter int NOPF_W     = 5,
   parameter int SCALE_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [NOPF_W-1:0] n_field,
   input  logic              blk_bit,
   input  logic              sr_exit,
   output logic              start,
   output logic              busy
);
   localparam int CNT_W = NOPF_W + SCALE_LOG2 + 1;

   if (NOPF_W < 1 || NOPF_W > 5) begin : g_bad_nopf
      $error("sdcg_stall: NOPF_W must be 1..5");
   end
   if (SCALE_LOG2 < 0 || SCALE_LOG2 > 8) begin : g_bad_scale
      $error("sdcg_stall: SCALE_LOG2 must be 0..8");
   end

   logic             blk_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] load_val;

   assign load_val = CNT_W'({1'b0, n_field} + {{NOPF_W{1'b0}}, 1'b1}) << SCALE_LOG2;
   assign start    = (blk_bit & ~blk_q) | sr_exit;
   assign busy     = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q <= 1'b0;
         cnt   <= '0;
      end else begin
         blk_q <= blk_bit;
         if (start)
            cnt <= load_val;
         else if (tick && busy)
            cnt <= cnt - 1'b1;
      end
   end

   a_r2_no_spontaneous_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && cnt == '0) |=> (cnt == '0));
   a_r2_count_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (!start) |=> (cnt <= $past(cnt)));
   a_r3_no_retrigger_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_bit && blk_q && !sr_exit && !busy) |=> !busy);
endmodule

// File: rtl/sdcg_cke.sv
module sdcg_cke (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pm_en,
   input  logic cs_idle,
   input  logic req_valid,
   output logic cke_q
);
   logic sleep_want;
   assign sleep_want = pm_en & cs_idle & ~req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cke_q <= 1'b1;
      else if (tick)
         cke_q <= ~sleep_want;
   end

   a_r6_pending_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && req_valid) |=> cke_q);
endmodule

// File: rtl/sdcg_apfmt.sv
module sdcg_apfmt #(
   parameter int ADDR_W     = 13,
   parameter int AP_BIT_DEF = 10,
   parameter int AP_BIT_ALT = 8
) (
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              rw,
   input  logic              ap,
   input  logic              sel_alt,
   output logic [ADDR_W-1:0] addr_out
);
   if (AP_BIT_DEF >= ADDR_W || AP_BIT_ALT >= ADDR_W || AP_BIT_DEF == AP_BIT_ALT) begin : g_bad_bits
      $error("sdcg_apfmt: precharge bit positions invalid for ADDR_W");
   end

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (i == AP_BIT_DEF) begin : g_def
         assign addr_out[i] = (rw && !sel_alt) ? ap : addr_in[i];
      end else if (i == AP_BIT_ALT) begin : g_alt
         assign addr_out[i] = (rw && sel_alt) ? ap : addr_in[i];
      end else begin : g_pass
         assign addr_out[i] = addr_in[i];
      end
   end
endmodule

// File: rtl/sdram_cmd_gate.sv
module sdram_cmd_gate
   import sdcg_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int NOPF_W     = 5,
   parameter int SCALE_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       cfg_word,
   input  logic              mclk_en,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_ap,
   input  logic              sr_exit,
   input  logic              cs_idle,
   output logic [2:0]        cmd_out,
   output logic              cke,
   output logic [ADDR_W-1:0] addr_out
);
   if (ADDR_W < 11) begin : g_bad_addr
      $error("sdram_cmd_gate: ADDR_W must be at least 11");
   end

   logic              tick;
   logic              stall_start;
   logic              stall_busy;
   logic              cke_q;
   logic              acc;
   logic              ap_sel_alt;
   logic [ADDR_W-1:0] fmt_addr;
   logic [2:0]        cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic              unused_cfg;

   assign unused_cfg = ^{cfg_word[31:27], cfg_word[23:16], cfg_word[14:8], cfg_word[6:5]};

   assign tick       = cfg_word[CFG_RATIO_BIT] | mclk_en;
   assign ap_sel_alt = (cfg_word[CFG_APSEL_LSB+1 -: 2] == 2'b01);

   sdcg_stall #(.NOPF_W(NOPF_W), .SCALE_LOG2(SCALE_LOG2)) u_stall (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .n_field (cfg_word[NOPF_W-1:0]),
      .blk_bit (cfg_word[CFG_BLK_BIT]),
      .sr_exit (sr_exit),
      .start   (stall_start),
      .busy    (stall_busy)
   );

   sdcg_cke u_cke (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .pm_en     (cfg_word[CFG_PM_BIT]),
      .cs_idle   (cs_idle),
      .req_valid (req_valid),
      .cke_q     (cke_q)
   );

   sdcg_apfmt #(.ADDR_W(ADDR_W)) u_apfmt (
      .addr_in  (req_addr),
      .rw       (is_rw(req_cmd)),
      .ap       (req_ap),
      .sel_alt  (ap_sel_alt),
      .addr_out (fmt_addr)
   );

   assign req_ready = tick & ~stall_busy & ~stall_start & cke_q;
   assign acc       = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= CMD_NOP;
         addr_q <= '0;
      end else if (tick) begin
         cmd_q <= acc ? req_cmd : CMD_NOP;
         if (acc) addr_q <= fmt_addr;
      end
   end

   assign cmd_out  = cmd_q;
   assign addr_out = addr_q;
   assign cke      = cke_q;

   a_r4_stall_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
      stall_busy |-> !req_ready);
   a_r6_cmd_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_out != CMD_NOP) |-> cke);
   a_r6_no_cmd_on_wake_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> (cmd_out == CMD_NOP));
   a_r7_ap_on_bit8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && is_rw(req_cmd) && cfg_word[25:24] == 2'b01) |=> (addr_out[8] == $past(req_ap)));
   a_r5_pm_off_keeps_cke: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cfg_word[CFG_PM_BIT]) |=> cke);
   a_r10_idle_gives_nop: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !acc) |=> (cmd_out == CMD_NOP));
endmodule

// File: tb/tb_sdram_cmd_gate.sv
`timescale 1ns/1ps
module tb_sdram_cmd_gate;
   localparam int AW = 13;
   localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, REF = 3'd5;
   localparam logic [31:0] RATIO1 = 32'h0000_8000;
   localparam logic [31:0] RSVD   = 32'hE8F5_7F60;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   cfg_word = '0;
   logic          mclk_en = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [2:0]    req_cmd = '0;
   logic [AW-1:0] req_addr = '0;
   logic          req_ap = 1'b0;
   logic          sr_exit = 1'b0;
   logic          cs_idle = 1'b0;
   logic [2:0]    cmd_out;
   logic          cke;
   logic [AW-1:0] addr_out;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   sdram_cmd_gate #(.ADDR_W(AW)) dut (.*);

   always #2 clk = ~clk;
   always @(posedge clk) mclk_en <= ~mclk_en;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Samples at falling edges until ready; returns memory clocks and bus cycles spent stalled.
   task automatic measure(input bit full_rate, output int ticks, output int bus, output int bad_cmd);
      ticks = 0; bus = 0; bad_cmd = 0;
      while (!req_ready && bus < 5000) begin
         if (full_rate || mclk_en) ticks++;
         if (cmd_out != NOP) bad_cmd++;
         @(negedge clk);
         bus++;
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 cmd_out", cmd_out, NOP);
      check("R1 cke", cke, 1);
      check("R1 addr_out", addr_out, 0);
      check("R1 ready follows mclk_en", req_ready, mclk_en);
      @(negedge clk);
      check("R1 ready follows mclk_en (next)", req_ready, mclk_en);
   endtask

   task automatic t_half_rate_stall;
      int tk, bs, bad;
      cfg_word = 32'h0;
      sr_exit = 1'b1;
      @(negedge clk);
      sr_exit = 1'b0;
      measure(1'b0, tk, bs, bad);
      check("R8 half-rate stall memory clocks", tk, 16);
      check("R8 half-rate stall spans bus cycles", int'(bs >= 31), 1);
   endtask

   task automatic t_sr_exit_stall;
      int tk, bs, bad;
      @(negedge clk);
      cfg_word = RATIO1 | 32'd2;
      req_valid = 1'b1; req_cmd = ACT; req_addr = 13'h0123; req_ap = 1'b0;
      sr_exit = 1'b1;
      @(negedge clk);
      sr_exit = 1'b0;
      measure(1'b1, tk, bs, bad);
      check("R2 self-refresh exit stall length N=2", tk, 48);
      check("R4 no command during stall", bad, 0);
      check("R4 ready returns after stall", req_ready, 1);
      @(negedge clk);
      check("R4 held request granted after stall", cmd_out, ACT);
      check("R10 address of granted request", addr_out, 13'h0123);
      req_valid = 1'b0;
      @(negedge clk);
      check("R10 nop with no grant", cmd_out, NOP);
   endtask

   task automatic t_block_access;
      int tk, bs, bad, low;
      @(negedge clk);
      cfg_word = RATIO1 | 32'h80;
      @(negedge clk);
      measure(1'b1, tk, bs, bad);
      check("R3 blackout stall length N=0", tk, 16);
      low = 0;
      for (int i = 0; i < 24; i++) begin
         if (!req_ready) low++;
         @(negedge clk);
      end
      check("R3 bit held high does not restart", low, 0);
      cfg_word = RATIO1 | 32'd1;
      @(negedge clk);
      cfg_word = RATIO1 | 32'h81;
      @(negedge clk);
      cfg_word = RATIO1 | 32'd1;
      measure(1'b1, tk, bs, bad);
      check("R3 clear then set restarts, N=1", tk, 32);
      check("R4 nop during blackout", bad, 0);
   endtask

   task automatic t_power_down;
      @(negedge clk);
      cfg_word = RATIO1 | 32'h0400_0000;
      cs_idle = 1'b1;
      @(negedge clk);
      check("R5 cke low when idle with power mode", cke, 0);
      check("R6 no ready while cke low", req_ready, 0);
      req_valid = 1'b1; req_cmd = REF; req_addr = '0;
      @(negedge clk);
      check("R6 cke raised by pending refresh", cke, 1);
      check("R6 no command on cke rise", cmd_out, NOP);
      check("R6 ready one clock after cke", req_ready, 1);
      @(negedge clk);
      check("R6 refresh issued", cmd_out, REF);
      req_valid = 1'b0;
      @(negedge clk);
      check("R5 cke drops again when idle", cke, 0);
      cfg_word = RATIO1;
      @(negedge clk);
      check("R5 cke high with power mode off", cke, 1);
      @(negedge clk);
      check("R5 cke stays high while idle", cke, 1);
      cs_idle = 1'b0;
   endtask

   task automatic issue(input string req, input logic [2:0] c, input logic [AW-1:0] a,
                        input logic ap, input logic [AW-1:0] exp);
      @(negedge clk);
      check({req, " ready before issue"}, req_ready, 1);
      req_valid = 1'b1; req_cmd = c; req_addr = a; req_ap = ap;
      @(negedge clk);
      check({req, " command"}, cmd_out, c);
      check({req, " address"}, addr_out, exp);
      req_valid = 1'b0;
   endtask

   task automatic t_ap_select;
      cfg_word = RATIO1;
      issue("R7 sel00 bit10", RD, 13'h0000, 1'b1, 13'h0400);
      cfg_word = RATIO1 | 32'h0100_0000;
      issue("R7 sel01 bit8", WR, 13'h0000, 1'b1, 13'h0100);
      issue("R7 sel01 clear bit8", RD, 13'h1FFF, 1'b0, 13'h1EFF);
      cfg_word = RATIO1 | 32'h0200_0000;
      issue("R7 sel10 falls back to bit10", RD, 13'h0000, 1'b1, 13'h0400);
      cfg_word = RATIO1 | 32'h0300_0000;
      issue("R7 sel11 falls back to bit10", WR, 13'h1FFF, 1'b0, 13'h1BFF);
      cfg_word = RATIO1;
      issue("R7 activate passes address", ACT, 13'h0555, 1'b0, 13'h0555);
      @(negedge clk);
      check("R10 nop after single grant", cmd_out, NOP);
   endtask

   task automatic t_reserved;
      int low;
      @(negedge clk);
      cfg_word = RATIO1 | RSVD;
      cs_idle = 1'b1;
      low = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (!req_ready || !cke) low++;
      end
      check("R9 reserved bits cause no stall or power-down", low, 0);
      issue("R9 reserved bits leave precharge on bit10", RD, 13'h0000, 1'b1, 13'h0400);
      cs_idle = 1'b0;
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_half_rate_stall();
      t_sr_exit_stall();
      t_block_access();
      t_power_down();
      t_ap_select();
      t_reserved();
      finish_run();
   end
endmodule